// File: doc/BRIEF.md
# Multi-Channel Event Timer

This block keeps a 64-bit free-running tick counter and a set of comparator channels (three by default) that raise events when the low 32 bits of the counter reach a programmed value. Software reaches every register through one 32-bit write/read port. Each write takes effect at the clock edge. A read returns data in the same cycle for the address currently presented.

A channel runs either once or periodically. Its event goes out on its own interrupt line, as a one-cycle pulse or as a held level. It can instead be sent as a message write that carries a programmed data word and address. A global routing bit moves channels 0 and 1 onto two dedicated legacy lines, for use by a system that expects a fixed tick and clock interrupt.

Periodic channels use a two-step setup. A comparator write made while the set-value bit is 1 places the first match time and clears that bit. The next comparator write gives the period that is added at every later match.

Top module: `evt_timer_top`

## Requirements
- R1: When global configuration bit 0 (run) is 1, the counter increases by one every clock and carries from the low word into the high word. The low word reads at 0x0F0 and the high word at 0x0F4.
- R2: When run is 0, the counter keeps its value. A write to 0x0F0 or 0x0F4 replaces that half of the counter, whether run is 0 or 1.
- R3: Address 0x000 reads the number of channels minus one in bits 4:0 and a 1 in bit 8, meaning legacy routing is supported. Address 0x004 reads the tick length in femtoseconds.
- R4: Channel n has its configuration at 0x100+0x20*n. Its writable bits are: 0 = level mode, 1 = enable, 2 = periodic, 3 = 32-bit force, 4 = set-value and 5 = message enable. Bits 8 and 9 read 1, meaning the channel can run periodically and can send messages.
- R5: An enabled one-shot channel in edge mode (level=0) pulses its line for exactly one cycle. The pulse comes one cycle after the cycle in which the counter low word equals the comparator at +0x08. The comparator keeps its value.
- R6: In level mode a match sets status bit n at 0x020. The line stays high until software writes 1 to that bit.
- R7: In periodic mode, a comparator write made while set-value is 1 loads the comparator and clears set-value. The next comparator write stores the period, and every match adds the period to the comparator.
- R8: When global configuration bit 1 (legacy route) is 1, channel 0's event appears on legacy_tick and channel 1's on legacy_clk. irq_lines bits 0 and 1 then stay 0.
- R9: With message enable set, a match produces a one-cycle msg_valid one cycle later. It carries the data word at +0x10 and the address at +0x14, and the channel's line stays 0. When several channels match in the same cycle, the lowest channel number is sent.
- R10: Clearing message enable masks messages: a match then gives no msg_valid and drives the line instead.
- R11: After reset the counter, the status register, the global configuration and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| irq_lines | output | NCH | Per-channel interrupt lines |
| legacy_tick | output | 1 | Channel 0 event under legacy routing |
| legacy_clk | output | 1 | Channel 1 event under legacy routing |
| msg_valid | output | 1 | Message write strobe |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data word |

## Verification
The counter assertions assume that a write to either counter half is the only thing that overrides counting. The bench therefore halts the counter and writes zeros before each scenario. The routing check assumes that the legacy bit changes only while no channel is firing. The bench changes that bit only through a restart sequence with every channel idle. The message check assumes software writes no comparator during a match cycle. Comparators are programmed only while the counter is halted, and the match times are chosen far apart.

// File: rtl/evt_timer_pkg.sv
// Package: shared register offsets and channel configuration bit positions
// for the event timer. Assumes 12-bit byte addressing with 32-bit registers.
package evt_timer_pkg;
    localparam int AW = 12;
    localparam logic [AW-1:0] OFF_CAP    = 12'h000;
    localparam logic [AW-1:0] OFF_TICK   = 12'h004;
    localparam logic [AW-1:0] OFF_GCFG   = 12'h010;
    localparam logic [AW-1:0] OFF_STS    = 12'h020;
    localparam logic [AW-1:0] OFF_CNT_LO = 12'h0F0;
    localparam logic [AW-1:0] OFF_CNT_HI = 12'h0F4;
    localparam logic [3:0]    CH_WINDOW  = 4'h1;
    localparam logic [4:0]    SUB_CFG    = 5'h00;
    localparam logic [4:0]    SUB_CMP    = 5'h08;
    localparam logic [4:0]    SUB_RDATA  = 5'h10;
    localparam logic [4:0]    SUB_RADDR  = 5'h14;
    localparam int CB_LEVEL  = 0;
    localparam int CB_EN     = 1;
    localparam int CB_PER    = 2;
    localparam int CB_F32    = 3;
    localparam int CB_SETVAL = 4;
    localparam int CB_MSG    = 5;

    typedef struct packed {
        logic msg_en;
        logic setval;
        logic force32;
        logic periodic;
        logic enable;
        logic level;
    } chan_cfg_t;
endpackage

// File: rtl/evt_main_counter.sv
// Main counter: a 64-bit up-counter that advances while run is high.
// Assumes a half-word write wins over counting in the same cycle.
module evt_main_counter #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [31:0]   wdata,
    output logic [CW-1:0] count
);
    localparam int HALF = CW / 2;

    // Count, or load one half from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo) begin
            count[HALF-1:0] <= wdata[HALF-1:0];
        end else if (wr_hi) begin
            count[CW-1:HALF] <= wdata[HALF-1:0];
        end else if (run) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/evt_channel.sv
// One comparator channel: holds configuration, comparator, period and
// message route, detects a match against the counter low word and forms
// the edge pulse or level status. Assumes only one register write per cycle.
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter bit PER_CAP = 1'b1,
    parameter bit MSG_CAP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cmp_we,
    input  logic        rdat_we,
    input  logic        radr_we,
    input  logic        sts_clr,
    input  logic [31:0] wdata,
    input  logic [31:0] cnt_lo,
    input  logic        cnt_run,
    output logic [31:0] cfg_rd,
    output logic [31:0] cmp_q,
    output logic [31:0] rte_data,
    output logic [31:0] rte_addr,
    output logic        match,
    output logic        sts,
    output logic        line,
    output logic        msg_en
);
    chan_cfg_t   cfg;
    logic [31:0] period;
    logic        pulse_q;

    // A match happens only while the channel is enabled and time advances.
    assign match  = cfg.enable && cnt_run && (cnt_lo == cmp_q);
    assign msg_en = cfg.msg_en;

    // Configuration, comparator and period, including the set-value sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '0;
            cmp_q  <= '0;
            period <= '0;
        end else if (cfg_we) begin
            cfg.level    <= wdata[CB_LEVEL];
            cfg.enable   <= wdata[CB_EN];
            cfg.periodic <= wdata[CB_PER] & PER_CAP;
            cfg.force32  <= wdata[CB_F32];
            cfg.setval   <= wdata[CB_SETVAL];
            cfg.msg_en   <= wdata[CB_MSG] & MSG_CAP;
        end else if (cmp_we) begin
            if (cfg.periodic && !cfg.setval) begin
                period <= wdata;
            end else begin
                cmp_q      <= wdata;
                cfg.setval <= 1'b0;
            end
        end else if (match && cfg.periodic) begin
            cmp_q <= cmp_q + period;
        end
    end

    // Message route data word and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rte_data <= '0;
            rte_addr <= '0;
        end else begin
            if (rdat_we) rte_data <= wdata;
            if (radr_we) rte_addr <= wdata;
        end
    end

    // Edge pulse and sticky level status; a new match beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            sts     <= 1'b0;
        end else begin
            pulse_q <= match && !cfg.level;
            if (match && cfg.level) sts <= 1'b1;
            else if (sts_clr)       sts <= 1'b0;
        end
    end

    // The line is silent while messages carry the event.
    assign line = !cfg.msg_en && (cfg.level ? sts : pulse_q);

    assign cfg_rd = {22'b0, MSG_CAP, PER_CAP, 2'b0, cfg.msg_en, cfg.setval,
                     cfg.force32, cfg.periodic, cfg.enable, cfg.level};
endmodule

// File: rtl/evt_timer_top.sv
// Event timer top: register decode and read mux, global configuration,
// channel array, legacy routing and message arbitration (lowest channel wins).
// Assumes NCH is between 2 and 8 (0x20 stride inside the 0x100 window).
module evt_timer_top
    import evt_timer_pkg::*;
#(
    parameter int              NCH          = 3,
    parameter logic [31:0]     TICK_FS      = 32'd20_000_000,
    parameter logic [NCH-1:0]  PER_CAP_MASK = '1,
    parameter logic [NCH-1:0]  MSG_CAP_MASK = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [11:0]    reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic [NCH-1:0] irq_lines,
    output logic           legacy_tick,
    output logic           legacy_clk,
    output logic           msg_valid,
    output logic [31:0]    msg_addr,
    output logic [31:0]    msg_data
);
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [31:0] CAP_WORD = 32'h100 | 32'(NCH - 1);

    logic        glb_en, glb_leg;
    logic [63:0] count;
    logic        cnt_wr;
    logic        ch_hit;
    logic [2:0]  ch_idx;
    logic [4:0]  ch_sub;

    logic [31:0]    ch_cfg_rd [NCH];
    logic [31:0]    ch_cmp    [NCH];
    logic [31:0]    ch_rdat   [NCH];
    logic [31:0]    ch_radr   [NCH];
    logic [NCH-1:0] ch_match, ch_sts, ch_line, ch_msg;
    logic           pick_ok;
    logic [CIW-1:0] pick;

    assign ch_hit = (reg_addr[11:8] == CH_WINDOW);
    assign ch_idx = reg_addr[7:5];
    assign ch_sub = reg_addr[4:0];
    assign cnt_wr = reg_we && (reg_addr == OFF_CNT_LO || reg_addr == OFF_CNT_HI);

    // Global run and legacy-route bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en  <= 1'b0;
            glb_leg <= 1'b0;
        end else if (reg_we && reg_addr == OFF_GCFG) begin
            glb_en  <= reg_wdata[0];
            glb_leg <= reg_wdata[1];
        end
    end

    evt_main_counter #(.CW(64)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (glb_en),
        .wr_lo (reg_we && reg_addr == OFF_CNT_LO),
        .wr_hi (reg_we && reg_addr == OFF_CNT_HI),
        .wdata (reg_wdata),
        .count (count)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = reg_we && ch_hit && (ch_idx == 3'(c));
        evt_channel #(
            .PER_CAP (PER_CAP_MASK[c]),
            .MSG_CAP (MSG_CAP_MASK[c])
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (sel && ch_sub == SUB_CFG),
            .cmp_we   (sel && ch_sub == SUB_CMP),
            .rdat_we  (sel && ch_sub == SUB_RDATA),
            .radr_we  (sel && ch_sub == SUB_RADDR),
            .sts_clr  (reg_we && reg_addr == OFF_STS && reg_wdata[c]),
            .wdata    (reg_wdata),
            .cnt_lo   (count[31:0]),
            .cnt_run  (glb_en),
            .cfg_rd   (ch_cfg_rd[c]),
            .cmp_q    (ch_cmp[c]),
            .rte_data (ch_rdat[c]),
            .rte_addr (ch_radr[c]),
            .match    (ch_match[c]),
            .sts      (ch_sts[c]),
            .line     (ch_line[c]),
            .msg_en   (ch_msg[c])
        );
    end

    // Legacy routing takes channels 0 and 1 off their normal lines.
    always_comb begin
        irq_lines   = ch_line;
        legacy_tick = 1'b0;
        legacy_clk  = 1'b0;
        if (glb_leg) begin
            legacy_tick  = ch_line[0];
            legacy_clk   = ch_line[1];
            irq_lines[0] = 1'b0;
            irq_lines[1] = 1'b0;
        end
    end

    // Choose the lowest-numbered channel with a message match.
    always_comb begin
        pick_ok = 1'b0;
        pick    = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (ch_match[c] && ch_msg[c]) begin
                pick_ok = 1'b1;
                pick    = CIW'(c);
            end
        end
    end

    // Register the outgoing message write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else begin
            msg_valid <= pick_ok;
            if (pick_ok) begin
                msg_addr <= ch_radr[pick];
                msg_data <= ch_rdat[pick];
            end
        end
    end

    // Read mux over global and channel registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CAP:    reg_rdata = CAP_WORD;
            OFF_TICK:   reg_rdata = TICK_FS;
            OFF_GCFG:   reg_rdata = {30'b0, glb_leg, glb_en};
            OFF_STS:    reg_rdata = 32'(ch_sts);
            OFF_CNT_LO: reg_rdata = count[31:0];
            OFF_CNT_HI: reg_rdata = count[63:32];
            default:    reg_rdata = '0;
        endcase
        for (int c = 0; c < NCH; c++) begin
            if (ch_hit && ch_idx == 3'(c)) begin
                case (ch_sub)
                    SUB_CFG:   reg_rdata = ch_cfg_rd[c];
                    SUB_CMP:   reg_rdata = ch_cmp[c];
                    SUB_RDATA: reg_rdata = ch_rdat[c];
                    SUB_RADDR: reg_rdata = ch_radr[c];
                    default:   reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_timer_chk.sv
// Checker for the event timer: counter stepping and holding, legacy line
// exclusivity and message timing. Bound to every evt_timer_top instance.
module evt_timer_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           glb_en,
    input logic           cnt_wr,
    input logic [63:0]    count,
    input logic [NCH-1:0] irq_lines,
    input logic           legacy_tick,
    input logic           legacy_clk,
    input logic           msg_valid,
    input logic           pick_ok
);
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && !cnt_wr) |=> (count == $past(count) + 64'd1));

    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !cnt_wr) |=> $stable(count));

    assert_legacy_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(legacy_tick && irq_lines[0]) && !(legacy_clk && irq_lines[1]));

    assert_msg_follows_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pick_ok |=> msg_valid);

    assert_msg_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(pick_ok));
endmodule

bind evt_timer_top evt_timer_chk #(.NCH(NCH)) u_evt_timer_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_en      (glb_en),
    .cnt_wr      (cnt_wr),
    .count       (count),
    .irq_lines   (irq_lines),
    .legacy_tick (legacy_tick),
    .legacy_clk  (legacy_clk),
    .msg_valid   (msg_valid),
    .pick_ok     (pick_ok)
);

// File: tb/test_evt_timer_top.sv
// Bench: directed register sequences; expected messages go into a
// scoreboard queue that a monitor drains as msg_valid appears.
module test_evt_timer_top;
    localparam int NCH = 3;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] irq_lines;
    logic legacy_tick, legacy_clk, msg_valid;
    logic [31:0] msg_addr, msg_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    logic [63:0] exp_q [$];

    always #10 clk = ~clk;

    evt_timer_top #(.NCH(NCH)) i_evt_timer_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
        .legacy_tick(legacy_tick), .legacy_clk(legacy_clk),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [11:0] ch_reg(int ch, logic [4:0] sub);
        return 12'h100 + 12'(ch * 32) + 12'(sub);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands at the next posedge.
    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, 64'(reg_rdata), 64'(exp));
    endtask

    // Halt, zero the counter, set the legacy bit, idle all channels.
    task automatic restart(bit leg);
        wr(12'h010, {30'b0, leg, 1'b0});
        wr(12'h0F0, 32'h0);
        wr(12'h0F4, 32'h0);
        for (int c = 0; c < NCH; c++) wr(ch_reg(c, 5'h00), 32'h0);
        wr(12'h020, 32'hFFFF_FFFF);
    endtask

    // Scoreboard monitor for message writes (R9, R10).
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R10: actual unexpected message %h/%h expected none",
                         msg_addr, msg_data);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check("R9", {msg_addr, msg_data}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd_chk("R11", 12'h0F0, 32'h0);
        rd_chk("R11", 12'h020, 32'h0);
        rd_chk("R11", 12'h010, 32'h0);
        check("R11", {irq_lines, legacy_tick, legacy_clk, msg_valid}, '0);
        // R3 capability and tick length
        rd_chk("R3", 12'h000, 32'h0000_0102);
        rd_chk("R3", 12'h004, 32'd20_000_000);

        // R1 counting
        restart(0);
        wr(12'h010, 32'h1);
        repeat (5) @(negedge clk);
        rd_chk("R1", 12'h0F0, 32'd5);

        // R1 carry into high word, R2 half writes and halt
        wr(12'h010, 32'h0);
        wr(12'h0F0, 32'hFFFF_FFFE);
        wr(12'h0F4, 32'h1);
        wr(12'h010, 32'h1);
        repeat (3) @(negedge clk);
        wr(12'h010, 32'h0);
        rd_chk("R1", 12'h0F4, 32'h2);
        rd_chk("R1", 12'h0F0, 32'h2);
        repeat (4) @(negedge clk);
        rd_chk("R2", 12'h0F0, 32'h2);

        // R5 one-shot edge on channel 0, R4 config readback
        restart(0);
        wr(ch_reg(0, 5'h00), 32'h0000_0002);
        wr(ch_reg(0, 5'h08), 32'd10);
        rd_chk("R4", ch_reg(0, 5'h00), 32'h0000_0302);
        wr(12'h010, 32'h1);
        repeat (10) @(negedge clk);
        check("R5", 64'(irq_lines[0]), 64'd0);
        @(negedge clk);
        check("R5", 64'(irq_lines[0]), 64'd1);
        @(negedge clk);
        check("R5", 64'(irq_lines[0]), 64'd0);
        rd_chk("R5", ch_reg(0, 5'h08), 32'd10);

        // R6 level mode on channel 1
        restart(0);
        wr(ch_reg(1, 5'h00), 32'h0000_0003);
        wr(ch_reg(1, 5'h08), 32'd6);
        wr(12'h010, 32'h1);
        repeat (6) @(negedge clk);
        check("R6", 64'(irq_lines[1]), 64'd0);
        @(negedge clk);
        check("R6", 64'(irq_lines[1]), 64'd1);
        rd_chk("R6", 12'h020, 32'h2);
        repeat (3) @(negedge clk);
        check("R6", 64'(irq_lines[1]), 64'd1);
        wr(12'h020, 32'h2);
        check("R6", 64'(irq_lines[1]), 64'd0);
        rd_chk("R6", 12'h020, 32'h0);

        // R7 periodic sequence on channel 2
        restart(0);
        wr(ch_reg(2, 5'h00), 32'h0000_0016);
        wr(ch_reg(2, 5'h08), 32'd5);
        rd_chk("R7", ch_reg(2, 5'h00), 32'h0000_0306);
        wr(ch_reg(2, 5'h08), 32'd4);
        wr(12'h010, 32'h1);
        for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            check("R7", 64'(irq_lines[2]), 64'(i == 6 || i == 10 || i == 14));
        end
        rd_chk("R7", ch_reg(2, 5'h08), 32'd17);

        // R8 legacy routing of channels 0 and 1
        restart(1);
        wr(ch_reg(0, 5'h00), 32'h0000_0002);
        wr(ch_reg(0, 5'h08), 32'd4);
        wr(ch_reg(1, 5'h00), 32'h0000_0003);
        wr(ch_reg(1, 5'h08), 32'd4);
        wr(12'h010, 32'h3);
        repeat (4) @(negedge clk);
        check("R8", 64'(legacy_tick), 64'd0);
        @(negedge clk);
        check("R8", {legacy_tick, legacy_clk, irq_lines[1:0]}, 64'b1100);
        @(negedge clk);
        check("R8", {legacy_tick, legacy_clk, irq_lines[1:0]}, 64'b0100);

        // R9 message delivery on channel 1
        restart(0);
        wr(ch_reg(1, 5'h10), 32'hDEAD_0001);
        wr(ch_reg(1, 5'h14), 32'hFEE0_0004);
        wr(ch_reg(1, 5'h00), 32'h0000_0022);
        wr(ch_reg(1, 5'h08), 32'd3);
        exp_q.push_back({32'hFEE0_0004, 32'hDEAD_0001});
        wr(12'h010, 32'h1);
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check("R9", 64'(irq_lines[1]), 64'd0);
        end
        check("R9", 64'(exp_q.size()), 64'd0);

        // R10 masking moves the event back to the line
        restart(0);
        wr(ch_reg(1, 5'h00), 32'h0000_0002);
        wr(12'h010, 32'h1);
        repeat (3) @(negedge clk);
        check("R10", 64'(irq_lines[1]), 64'd0);
        @(negedge clk);
        check("R10", 64'(irq_lines[1]), 64'd1);
        repeat (3) @(negedge clk);
        check("R10", 64'(exp_q.size()), 64'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule